// File: doc/BRIEF.md
# USB Low-Speed Serial Receiver

This block turns the two data lines of a USB low-speed link into received bytes. The lines arrive already synchronised to a 12 MHz system clock, which gives eight clocks per 1.5 Mbit/s bit. The receiver watches the idle state. It is armed by the first K level, and it locks onto the sync field by finding a J-to-K transition and then a second K bit straight after it. From then on it samples each bit at its centre, and its phase is pulled back into line on every transition. It undoes the NRZI coding, throws away stuffed bits and assembles bytes least significant bit first.

Each finished byte is presented for one cycle on a byte output with a valid strobe. A single-ended zero (both lines low) closes the packet. The check for it is not made in the first bit slot of a byte, because a hub may add a dribble bit there. At the close the block pulses an end strobe with the count of whole bytes, and it marks packets shorter than three bytes as handshakes. A failed sync hunt and a packet longer than the byte budget each raise their own one-cycle error pulse.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, byteValid, pktEnd, pktShort, errSync and errOverflow are 0 and pktLen is 0.
- R2: J is dMinus=1 with dPlus=0, K is dMinus=0 with dPlus=1, and SE0 is both low. A K on an idle line arms the receiver. It then waits for dMinus high and hunts for a K. Reception starts only if the bit sampled one bit time after that K edge is also K. Otherwise the hunt resumes, so a sync of alternating K and J bits that never shows two K bits in a row delivers no byte and no pktEnd.
- R3: If no K arrives within HUNT_WIN clocks after entering the hunt, errSync pulses for exactly one cycle and no byte is delivered.
- R4: Each data bit decodes to 1 when the dMinus level equals the previous bit's level and to 0 when it differs. The last sync bit (K) is the starting level. Bytes are assembled LSB first, and each is shown on byteData with a one-cycle byteValid.
- R5: After six decoded 1s in a row, the next bit is sampled and discarded. The final sync bit counts as the first 1 of such a run.
- R6: An SE0 sample ends the packet, except when it falls in the first bit slot of a byte. pktEnd then pulses for one cycle, and pktLen gives the number of whole bytes delivered and holds that value until the next sync.
- R7: Bits of an unfinished byte at SE0 are dropped. This includes an SE0 that lands in the slot of a byte's eighth bit, which ends the packet instead of completing the byte.
- R8: pktShort pulses together with pktEnd when pktLen is below 3. It is never high without pktEnd.
- R9: With BUF_BYTES bytes already delivered, completing one more byte raises a one-cycle errOverflow instead of byteValid. Reception then stops with no pktEnd.
- R10: At most one of pktEnd, errSync and errOverflow is high in any cycle.
- R11: Bit sampling follows the packet's own timing whatever clock phase the packet starts on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLKS_PER_BIT clocks per bit |
| rstN | input | 1 | Active-low synchronous reset |
| dPlus | input | 1 | Synchronised D+ line |
| dMinus | input | 1 | Synchronised D- line |
| byteData | output | 8 | Received byte, valid with byteValid |
| byteValid | output | 1 | One-cycle strobe per delivered byte |
| pktEnd | output | 1 | One-cycle end-of-packet strobe |
| pktLen | output | LEN_W | Whole bytes in the current or last packet |
| pktShort | output | 1 | Handshake marker, pulses with pktEnd when pktLen < 3 |
| errSync | output | 1 | One-cycle sync hunt timeout |
| errOverflow | output | 1 | One-cycle byte budget overflow |

## Verification
The end-of-packet detector and the byte completion path can act on the same sample. This happens when an SE0 falls in the slot of a byte's eighth bit. If the buffer is already full, that same sample is also the one that would raise an overflow. The bench provokes this by sending packets cut off after exactly seven extra bits, one with a short payload and one with a full buffer. It judges that pktEnd wins: the partial byte is not delivered, pktLen counts only whole bytes, and errOverflow stays low. Normal end-of-packet, where the first SE0 falls in slot 0 and must be passed over, is covered by every other packet.

// File: rtl/usb_ls_rx_pkg.sv
`timescale 1ns/1ps
package usb_ls_rx_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic clearRx;  // sync accepted: initialise decoder state
    logic runRx;    // receive in progress
  } rx_ctl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAITJ,
    S_HUNT,
    S_CHECK,
    S_RECV
  } rx_state_t;

endpackage

// File: rtl/usb_ls_rx_dp.sv
`timescale 1ns/1ps
module usb_ls_rx_dp
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int BUF_BYTES    = 11,
  parameter int STUFF_RUN    = 6,
  localparam int LEN_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dPlus,
  input  logic             dMinus,
  input  rx_ctl_t          ctl,
  output logic             tick,
  output logic             endHit,
  output logic             ovfHit,
  output logic [LEN_W-1:0] byteCnt,
  output logic [7:0]       byteData,
  output logic             byteValid
);

  localparam int PH_W  = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(CLKS_PER_BIT / 2);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(STUFF_RUN);
  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(BUF_BYTES);

  logic             prevDm;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  phNow;
  logic             edgeSeen;
  logic             lastLvl;
  logic [RUN_W-1:0] onesCnt;
  logic [2:0]       slot;
  logic [6:0]       shreg;
  logic [7:0]       nextSh;
  logic             decoded;
  logic             stuffNow;
  logic             se0;
  logic             completing;

  // Bit-phase tracking: a dMinus transition marks phase 0 of a bit.
  assign edgeSeen = (dMinus != prevDm);
  assign phNow    = edgeSeen ? '0 : ph;
  assign tick     = (phNow == PH_SAMPLE);

  assign se0        = ~dPlus & ~dMinus;
  assign decoded    = (dMinus == lastLvl);
  assign stuffNow   = (onesCnt == RUN_MAX);
  assign nextSh     = {decoded, shreg};
  assign endHit     = ctl.runRx & tick & se0 & (slot != 3'd0);
  assign completing = ctl.runRx & tick & ~endHit & ~stuffNow & (slot == 3'd7);
  assign ovfHit     = completing & (byteCnt == LEN_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevDm    <= 1'b1;
      ph        <= '0;
      lastLvl   <= 1'b0;
      onesCnt   <= '0;
      slot      <= '0;
      shreg     <= '0;
      byteCnt   <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
    end else begin
      prevDm    <= dMinus;
      ph        <= edgeSeen ? PH_W'(1) : ((ph == PH_LAST) ? '0 : ph + 1'b1);
      byteValid <= 1'b0;
      if (ctl.clearRx) begin
        lastLvl <= 1'b0;          // sync ends on K
        onesCnt <= RUN_W'(1);     // final sync bit is a decoded 1
        slot    <= '0;
        shreg   <= '0;
        byteCnt <= '0;
      end else if (ctl.runRx && tick && !endHit) begin
        lastLvl <= dMinus;
        if (stuffNow) begin
          onesCnt <= '0;
        end else begin
          shreg   <= nextSh[7:1];
          onesCnt <= decoded ? onesCnt + 1'b1 : '0;
          slot    <= slot + 3'd1;
          if (completing && !ovfHit) begin
            byteValid <= 1'b1;
            byteData  <= nextSh;
            byteCnt   <= byteCnt + 1'b1;
          end
        end
      end
    end
  end

  // R4: a delivered byte lasts one cycle and only comes out of a receive
  p_byte_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
  p_byte_in_recv_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(ctl.runRx));
  // R5: the run of ones never passes the stuffing limit
  p_run_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= RUN_MAX);
  // R9: the overflowing byte is never delivered
  p_no_overflow_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfHit |=> !byteValid);

endmodule

// File: rtl/usb_ls_rx_ctrl.sv
`timescale 1ns/1ps
module usb_ls_rx_ctrl
  import usb_ls_rx_pkg::*;
#(
  parameter int HUNT_WIN  = 16,
  parameter int SHORT_LEN = 3,
  parameter int LEN_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dPlus,
  input  logic             dMinus,
  input  logic             tick,
  input  logic             endHit,
  input  logic             ovfHit,
  input  logic [LEN_W-1:0] byteCnt,
  output rx_ctl_t          ctl,
  output logic             pktEnd,
  output logic             pktShort,
  output logic             errSync,
  output logic             errOverflow
);

  localparam int HUNT_W = $clog2(HUNT_WIN + 1);
  localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(HUNT_WIN - 1);

  rx_state_t         state;
  logic [HUNT_W-1:0] huntCnt;
  logic              chkSeen;
  logic              lineK;

  assign lineK = dPlus & ~dMinus;

  always_comb begin
    ctl         = '0;
    ctl.runRx   = (state == S_RECV);
    ctl.clearRx = (state == S_CHECK) & tick & chkSeen & lineK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      huntCnt     <= '0;
      chkSeen     <= 1'b0;
      pktEnd      <= 1'b0;
      pktShort    <= 1'b0;
      errSync     <= 1'b0;
      errOverflow <= 1'b0;
    end else begin
      pktEnd      <= 1'b0;
      pktShort    <= 1'b0;
      errSync     <= 1'b0;
      errOverflow <= 1'b0;
      unique case (state)
        S_IDLE:  if (lineK) state <= S_WAITJ;
        S_WAITJ: if (dMinus) begin
          state   <= S_HUNT;
          huntCnt <= '0;
        end
        S_HUNT: begin
          if (lineK) begin
            state   <= S_CHECK;
            chkSeen <= 1'b0;
          end else if (huntCnt == HUNT_LAST) begin
            errSync <= 1'b1;
            state   <= S_IDLE;
          end else begin
            huntCnt <= huntCnt + 1'b1;
          end
        end
        S_CHECK: if (tick) begin
          if (!chkSeen) begin
            chkSeen <= 1'b1;      // centre of the first K: wait one more bit
          end else if (lineK) begin
            state <= S_RECV;
          end else begin
            state   <= S_HUNT;
            huntCnt <= '0;
          end
        end
        S_RECV: begin
          if (endHit) begin
            pktEnd   <= 1'b1;
            pktShort <= (byteCnt < LEN_W'(SHORT_LEN));
            state    <= S_IDLE;
          end else if (ovfHit) begin
            errOverflow <= 1'b1;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: terminal events are exclusive
  p_events_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pktEnd, errSync, errOverflow}));
  // R6: end strobe lasts one cycle
  p_end_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |=> !pktEnd);
  // R8: handshake marker only with an end strobe
  p_short_with_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    pktShort |-> pktEnd);
  // R3: a sync error comes from the hunt and returns to idle
  p_sync_err_from_hunt_r3: assert property (@(posedge clk) disable iff (!rstN)
    errSync |-> ($past(state) == S_HUNT) && (state == S_IDLE));
  // R2: receive is entered only on a K sample
  p_recv_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_RECV) && ($past(state) != S_RECV)) |-> $past(lineK));

endmodule

// File: rtl/usb_ls_rx.sv
`timescale 1ns/1ps
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int BUF_BYTES    = 11,
  parameter int HUNT_WIN     = 2 * CLKS_PER_BIT,
  parameter int STUFF_RUN    = 6,
  parameter int SHORT_LEN    = 3,
  localparam int LEN_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dPlus,
  input  logic             dMinus,
  output logic [7:0]       byteData,
  output logic             byteValid,
  output logic             pktEnd,
  output logic [LEN_W-1:0] pktLen,
  output logic             pktShort,
  output logic             errSync,
  output logic             errOverflow
);

  rx_ctl_t          ctl;
  logic             tick;
  logic             endHit;
  logic             ovfHit;
  logic [LEN_W-1:0] byteCnt;

  usb_ls_rx_dp #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .BUF_BYTES   (BUF_BYTES),
    .STUFF_RUN   (STUFF_RUN)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dPlus    (dPlus),
    .dMinus   (dMinus),
    .ctl      (ctl),
    .tick     (tick),
    .endHit   (endHit),
    .ovfHit   (ovfHit),
    .byteCnt  (byteCnt),
    .byteData (byteData),
    .byteValid(byteValid)
  );

  usb_ls_rx_ctrl #(
    .HUNT_WIN (HUNT_WIN),
    .SHORT_LEN(SHORT_LEN),
    .LEN_W    (LEN_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dPlus      (dPlus),
    .dMinus     (dMinus),
    .tick       (tick),
    .endHit     (endHit),
    .ovfHit     (ovfHit),
    .byteCnt    (byteCnt),
    .ctl        (ctl),
    .pktEnd     (pktEnd),
    .pktShort   (pktShort),
    .errSync    (errSync),
    .errOverflow(errOverflow)
  );

  assign pktLen = byteCnt;

endmodule

// File: tb/test_usb_ls_rx.sv
`timescale 1ns/1ps
module test_usb_ls_rx;

  localparam int CPB   = 8;
  localparam int BUF   = 11;
  localparam int LEN_W = $clog2(BUF + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dPlus = 1'b0;
  logic dMinus = 1'b1;
  logic [7:0] byteData;
  logic byteValid, pktEnd, pktShort, errSync, errOverflow;
  logic [LEN_W-1:0] pktLen;

  always #2.5 clk = ~clk;

  usb_ls_rx i_usb_ls_rx (
    .clk(clk), .rstN(rstN), .dPlus(dPlus), .dMinus(dMinus),
    .byteData(byteData), .byteValid(byteValid), .pktEnd(pktEnd),
    .pktLen(pktLen), .pktShort(pktShort), .errSync(errSync),
    .errOverflow(errOverflow)
  );

  // Monitor: records output events.
  int nBytes = 0, nEnd = 0, nSync = 0, nOvf = 0;
  int lastLen = 0;
  logic lastShort = 1'b0;
  logic [7:0] rxq [0:2047];

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid && nBytes < 2048) begin
        rxq[nBytes] = byteData;
        nBytes = nBytes + 1;
      end
      if (pktEnd) begin
        nEnd = nEnd + 1;
        lastLen = int'(pktLen);
        lastShort = pktShort;
      end
      if (errSync) nSync = nSync + 1;
      if (errOverflow) nOvf = nOvf + 1;
    end
  end

  int nChecks = 0, nFail = 0;
  logic [7:0] pkt [0:15];
  bit curJ;
  int ones;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 = K, 1 = J, 2 = SE0; held for one bit time
  task automatic putLine(input int kind);
    case (kind)
      0: begin dPlus = 1'b1; dMinus = 1'b0; end
      1: begin dPlus = 1'b0; dMinus = 1'b1; end
      default: begin dPlus = 1'b0; dMinus = 1'b0; end
    endcase
    repeat (CPB) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    if (!b) curJ = !curJ;
    putLine(curJ ? 1 : 0);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin
      curJ = !curJ;
      putLine(curJ ? 1 : 0);
      ones = 0;
    end
  endtask

  task automatic sendPkt(input int n, input int extra);
    curJ = 1'b1;
    ones = 0;
    for (int i = 0; i < 8; i++) sendBit(i == 7);     // sync
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) sendBit(pkt[k][i]);
    for (int i = 0; i < extra; i++) sendBit(1'($urandom_range(0, 1)));
    putLine(2);
    putLine(2);
    putLine(1);
    repeat (4) putLine(1);
    repeat ($urandom_range(0, CPB - 1)) @(negedge clk);   // R11 phase offset
  endtask

  task automatic runPacket(input int n, input int extra, input string tag);
    int b0, e0, s0, o0;
    b0 = nBytes; e0 = nEnd; s0 = nSync; o0 = nOvf;
    sendPkt(n, extra);
    chk(nBytes - b0 == n, {tag, " R4 byte count"}, nBytes - b0, n);
    for (int i = 0; i < n; i++)
      chk(rxq[b0 + i] == pkt[i], {tag, " R4 byte value"}, int'(rxq[b0 + i]), int'(pkt[i]));
    chk(nEnd - e0 == 1, {tag, " R6 end strobe"}, nEnd - e0, 1);
    chk(lastLen == n, {tag, " R6 R7 length"}, lastLen, n);
    chk(lastShort == (n < 3), {tag, " R8 handshake"}, int'(lastShort), int'(n < 3));
    chk((nSync - s0) + (nOvf - o0) == 0, {tag, " R10 no error"}, (nSync - s0) + (nOvf - o0), 0);
  endtask

  task automatic runAll();
    int b0, e0, s0, o0;
    void'($urandom(32'd20240));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(byteValid == 0, "R1 byteValid", int'(byteValid), 0);
    chk(pktEnd == 0 && pktShort == 0, "R1 pktEnd", int'(pktEnd), 0);
    chk(errSync == 0 && errOverflow == 0, "R1 errors", int'(errSync), 0);
    chk(pktLen == 0, "R1 pktLen", int'(pktLen), 0);
    repeat (4) putLine(1);

    // Directed: handshake, stuffing, empty
    pkt[0] = 8'hD2;
    runPacket(1, 0, "R8 handshake");
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'h3F;
    runPacket(4, 0, "R5 stuffing");
    pkt[0] = 8'hFC; pkt[1] = 8'h01; pkt[2] = 8'h00;
    runPacket(3, 0, "R5 R4 run from sync");
    runPacket(0, 0, "R6 empty");

    // Random packets
    for (int p = 0; p < 24; p++) begin
      int n;
      n = $urandom_range(0, BUF);
      for (int k = 0; k < n; k++)
        pkt[k] = ($urandom_range(0, 9) < 3) ? 8'hFF : 8'($urandom);
      runPacket(n, 0, "R4 R11 random");
    end

    // Truncated and colliding SE0 (R7, R9)
    for (int k = 0; k < BUF; k++) pkt[k] = 8'($urandom);
    runPacket(2, 5, "R7 partial");
    runPacket(2, 7, "R7 slot seven");
    runPacket(BUF, 7, "R7 R9 full plus seven");

    // Sync timeout (R3)
    b0 = nBytes; e0 = nEnd; s0 = nSync;
    putLine(0);
    repeat (6) putLine(1);
    chk(nSync - s0 == 1, "R3 sync timeout", nSync - s0, 1);
    chk(nBytes - b0 == 0 && nEnd - e0 == 0, "R3 no output", nBytes - b0, 0);

    // Sync without double K (R2)
    b0 = nBytes; e0 = nEnd; s0 = nSync;
    for (int i = 0; i < 10; i++) putLine(i % 2);
    repeat (6) putLine(1);
    chk(nBytes - b0 == 0, "R2 no bytes", nBytes - b0, 0);
    chk(nEnd - e0 == 0, "R2 no end", nEnd - e0, 0);
    chk(nSync - s0 == 1, "R2 R3 hunt gives up", nSync - s0, 1);

    // Overflow (R9)
    b0 = nBytes; e0 = nEnd; o0 = nOvf;
    for (int k = 0; k <= BUF; k++) pkt[k] = 8'($urandom);
    sendPkt(BUF + 1, 0);
    chk(nOvf - o0 == 1, "R9 overflow pulse", nOvf - o0, 1);
    chk(nBytes - b0 == BUF, "R9 bytes kept", nBytes - b0, BUF);
    chk(nEnd - e0 == 0, "R9 no end", nEnd - e0, 0);
    for (int i = 0; i < BUF; i++)
      chk(rxq[b0 + i] == pkt[i], "R9 byte value", int'(rxq[b0 + i]), int'(pkt[i]));
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule